// File: doc/BRIEF.md
# Receiver Equalization Handshake Controller

This block is a per-lane controller for the receiver equalization exchange of a high-speed serial link PHY. A requester, usually the link layer, places a 2-bit request code on the control input. The block starts a request only if it has seen the code at 00 since its last completion. It then works out what to ask of the link partner's transmitter. That is either a new preset or a triple of transmitter coefficients, derived from the partner's current 4-bit preset. For codes that need it, the block also runs an adaptation phase. This phase is modelled as a fixed number of cycles followed by a pass/fail input.

Completion is a one-cycle done pulse. During that pulse the 18-bit request value and the preset/coefficient selector are valid. An adaptation-done pulse in the same cycle means equalization succeeded. If it is absent, the requester must issue the request again. After the done pulse, the requester returns the code to 00 before it can start another request. A 3-bit debug output shows the current state. The block accepts a 3-bit preset hint and a 6-bit low-frequency/full-swing hint, but it does not use them.

Top module: `rxeq_handshake_ctrl`

## Requirements
- R1: `fsm_dbg_o` encodes the state as IDLE=0, PRESET=1, TXCOEFF=2, ADAPT=3, DONE=4. After a request is accepted, the states run in this order:
  - code 01: 1 then 4.
  - code 10: 2, then 3 for ADAPT_CYCLES cycles, then 4.
  - code 11: 1, then 3 for ADAPT_CYCLES cycles, then 4.
  - The state then returns to 0.
- R2: `eq_done_o` is high for exactly one cycle per accepted request. It rises 2 cycles after acceptance for code 01, and 2+ADAPT_CYCLES cycles after acceptance for codes 10 and 11.
- R3: After a done pulse, no request is accepted until `eq_req_i` has been 00 in the IDLE state. A nonzero code held after done leaves the state at 0 and produces no further done.
- R4: `adapt_done_o` is high only together with `eq_done_o`. It is high only for codes 10 and 11, and then equals `adapt_pass_i` as sampled in the last ADAPT cycle. It is never high for code 01.
- R5: `lffs_sel_o` is 1 whenever `eq_req_i` is 10 or 11, and 0 otherwise.
- R6: For codes 01 and 11, `preset_sel_o`=1 with done. `new_coef_o[3:0]` holds the next preset: partner preset + 1 for partner presets 0..9, and 0 for partner presets 10..15. `new_coef_o[17:4]` is zero.
- R7: For code 10, `preset_sel_o`=0 with done, and `new_coef_o` = {post[17:12], main[11:6], pre[5:0]}, where:
  - pre = partner preset bits [1:0]
  - post = partner preset >> 2
  - main = 63 - pre - post
- R8: While `eq_done_o` is low, `new_coef_o`, `preset_sel_o` and `adapt_done_o` are 0.
- R9: `preset_hint_i` and `lffs_hint_i` have no effect on any output.
- R10: While `rst_ni` is low, `fsm_dbg_o` is 0 and every other output driven by state is 0.
- R11: A code of 00 holds the state at IDLE with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane parallel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eq_req_i | input | 2 | Equalization request code |
| partner_preset_i | input | 4 | Link partner's current transmit preset |
| preset_hint_i | input | 3 | Accepted, ignored |
| lffs_hint_i | input | 6 | Accepted, ignored |
| adapt_pass_i | input | 1 | Modelled adaptation outcome |
| preset_sel_o | output | 1 | With done: 1 = preset, 0 = coefficient triple |
| lffs_sel_o | output | 1 | High when request code is 10 or 11 |
| new_coef_o | output | 18 | Requested preset or coefficients, valid with done |
| adapt_done_o | output | 1 | One-cycle adaptation success pulse |
| eq_done_o | output | 1 | One-cycle completion pulse |
| fsm_dbg_o | output | 3 | Debug state code |

## Verification
The bench builds the block with ADAPT_CYCLES=3, which keeps each ADAPT window short. With that setting, the bench can sweep every request code against all 16 partner presets and both pass values. This covers the preset wrap at 10 and the reserved presets 11..15. The ignored hint inputs change with every run. After each done, the bench holds the code nonzero for several cycles before returning it to 00, which exercises the re-arm rule.

// File: rtl/rxeq_pkg.sv
package rxeq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRESET  = 3'd1,
    ST_TXCOEFF = 3'd2,
    ST_ADAPT   = 3'd3,
    ST_DONE    = 3'd4
  } rxeq_state_e;

  localparam int unsigned REQ_W    = 2;
  localparam int unsigned PRESET_W = 4;
endpackage

// File: rtl/rxeq_coef_gen.sv
module rxeq_coef_gen #(
  parameter int unsigned COEF_W      = 6,
  parameter int unsigned FULL_SWING  = 63,
  parameter int unsigned NUM_PRESETS = 11
) (
  input  logic [rxeq_pkg::PRESET_W-1:0] preset_i,
  input  logic                          coef_mode_i,
  output logic [3*COEF_W-1:0]           value_o
);
  localparam int unsigned VAL_W = 3*COEF_W;

  logic [COEF_W-1:0] pre_c, post_c, main_c;
  logic [rxeq_pkg::PRESET_W-1:0] next_preset;

  always_comb begin
    pre_c  = COEF_W'(preset_i[1:0]);
    post_c = COEF_W'(preset_i >> 2);
    main_c = COEF_W'(FULL_SWING) - pre_c - post_c;
    // wrap to preset 0 past the last defined preset, reserved codes included
    if (32'(preset_i) >= NUM_PRESETS - 1) next_preset = '0;
    else                                  next_preset = preset_i + 1'b1;
    if (coef_mode_i) value_o = {post_c, main_c, pre_c};
    else             value_o = VAL_W'(next_preset);
  end
endmodule

// File: rtl/rxeq_adapt_timer.sv
module rxeq_adapt_timer #(
  parameter int unsigned ADAPT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (ADAPT_CYCLES > 1) ? $clog2(ADAPT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADAPT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || last_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = en_i && (cnt_q == CNT_LAST);

  // ADAPT window never overruns its length (R1)
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/rxeq_handshake_ctrl.sv
module rxeq_handshake_ctrl #(
  parameter int unsigned ADAPT_CYCLES = 16,
  parameter int unsigned COEF_W       = 6,
  parameter int unsigned FULL_SWING   = 63,
  parameter int unsigned NUM_PRESETS  = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            eq_req_i,
  input  logic [3:0]            partner_preset_i,
  input  logic [2:0]            preset_hint_i,
  input  logic [5:0]            lffs_hint_i,
  input  logic                  adapt_pass_i,
  output logic                  preset_sel_o,
  output logic                  lffs_sel_o,
  output logic [3*COEF_W-1:0]   new_coef_o,
  output logic                  adapt_done_o,
  output logic                  eq_done_o,
  output logic [2:0]            fsm_dbg_o
);
  import rxeq_pkg::*;

  localparam int unsigned VAL_W = 3*COEF_W;
  localparam logic [REQ_W-1:0] REQ_OFF   = 2'b00;
  localparam logic [REQ_W-1:0] REQ_COEF  = 2'b10;
  localparam logic [REQ_W-1:0] REQ_FULL  = 2'b11;

  rxeq_state_e       state_q;
  logic [REQ_W-1:0]  req_q;
  logic [VAL_W-1:0]  val_q, val_c;
  logic              sel_q, pass_q, armed_q;
  logic              adapt_last;
  logic              unused_inputs;

  assign unused_inputs = ^{preset_hint_i, lffs_hint_i};

  rxeq_coef_gen #(
    .COEF_W(COEF_W), .FULL_SWING(FULL_SWING), .NUM_PRESETS(NUM_PRESETS)
  ) u_coef_gen (
    .preset_i   (partner_preset_i),
    .coef_mode_i(eq_req_i == REQ_COEF),
    .value_o    (val_c)
  );

  rxeq_adapt_timer #(.ADAPT_CYCLES(ADAPT_CYCLES)) u_adapt_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_ADAPT),
    .last_o(adapt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= REQ_OFF;
      val_q   <= '0;
      sel_q   <= 1'b0;
      pass_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (eq_req_i == REQ_OFF) begin
            armed_q <= 1'b1;
          end else if (armed_q) begin
            armed_q <= 1'b0;
            req_q   <= eq_req_i;
            val_q   <= val_c;
            sel_q   <= (eq_req_i != REQ_COEF);
            pass_q  <= 1'b0;
            state_q <= (eq_req_i == REQ_COEF) ? ST_TXCOEFF : ST_PRESET;
          end
        end
        ST_PRESET:  state_q <= (req_q == REQ_FULL) ? ST_ADAPT : ST_DONE;
        ST_TXCOEFF: state_q <= ST_ADAPT;
        ST_ADAPT: if (adapt_last) begin
          pass_q  <= adapt_pass_i;
          state_q <= ST_DONE;
        end
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign eq_done_o    = (state_q == ST_DONE);
  assign adapt_done_o = eq_done_o && req_q[1] && pass_q;
  assign preset_sel_o = eq_done_o && sel_q;
  assign new_coef_o   = eq_done_o ? val_q : '0;
  assign lffs_sel_o   = eq_req_i[1];
  assign fsm_dbg_o    = state_q;

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_done_o |=> !eq_done_o);
  assert_done_origin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eq_done_o) |-> ($past(state_q) == ST_PRESET || $past(state_q) == ST_ADAPT));
  assert_after_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_done_o |=> (state_q == ST_IDLE && !armed_q));
  assert_adapt_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapt_done_o |-> (eq_done_o && req_q != 2'b01));
  assert_quiet_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eq_done_o |-> (new_coef_o == '0 && !preset_sel_o));
  assert_preset_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_sel_o |-> (32'(new_coef_o) < NUM_PRESETS));
  assert_coef_sum_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eq_done_o && !preset_sel_o) |->
      (32'(new_coef_o[COEF_W-1:0]) + 32'(new_coef_o[2*COEF_W-1:COEF_W])
       + 32'(new_coef_o[VAL_W-1:2*COEF_W]) == FULL_SWING));
endmodule

// File: tb/rxeq_handshake_ctrl_bench.sv
module rxeq_handshake_ctrl_bench;
  localparam int N = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  eq_req_i = 2'b00;
  logic [3:0]  partner_preset_i = '0;
  logic [2:0]  preset_hint_i = '0;
  logic [5:0]  lffs_hint_i = '0;
  logic        adapt_pass_i = 1'b0;
  logic        preset_sel_o, lffs_sel_o, adapt_done_o, eq_done_o;
  logic [17:0] new_coef_o;
  logic [2:0]  fsm_dbg_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  rxeq_handshake_ctrl #(.ADAPT_CYCLES(N)) u_rxeq_handshake_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(fsm_dbg_o == 3'd0, req, fsm_dbg_o, 0);
    chk(!eq_done_o && !adapt_done_o && !preset_sel_o && new_coef_o == 0,
        {req, " quiet"}, {eq_done_o, adapt_done_o, preset_sel_o}, 0);
  endtask

  function automatic logic [17:0] exp_val(input int code, input int pp);
    int pre, post, mn;
    if (code == 2) begin
      pre = pp % 4; post = pp / 4; mn = 63 - pre - post;
      return 18'(post * 4096 + mn * 64 + pre);
    end
    return (pp >= 10) ? 18'd0 : 18'(pp + 1);
  endfunction

  task automatic run(input int code, input int pp, input bit pass);
    int lat;
    lat = (code == 1) ? 2 : 2 + N;
    @(negedge clk_i);
    eq_req_i = 2'(code); partner_preset_i = 4'(pp); adapt_pass_i = pass;
    preset_hint_i = 3'(pp * 5 + code); lffs_hint_i = 6'(pp * 7 + 3);
    for (int c = 1; c <= lat; c++) begin
      int es;
      @(negedge clk_i);
      preset_hint_i = preset_hint_i + 3'd1; // R9 hints wiggle mid-request
      lffs_hint_i = ~lffs_hint_i;
      chk(lffs_sel_o == code[1], "R5", lffs_sel_o, code[1]);
      if (c == lat) es = 4;
      else if (c == 1) es = (code == 2) ? 2 : 1;
      else es = 3;
      chk(fsm_dbg_o == 3'(es), "R1", fsm_dbg_o, es);
      chk(eq_done_o == (c == lat), "R2", eq_done_o, c == lat);
      if (c < lat) begin
        chk(!adapt_done_o && !preset_sel_o && new_coef_o == 0, "R8",
            new_coef_o, 0);
      end else begin
        chk(adapt_done_o == (code != 1 && pass), "R4", adapt_done_o,
            code != 1 && pass);
        chk(preset_sel_o == (code != 2), code == 2 ? "R7" : "R6",
            preset_sel_o, code != 2);
        chk(new_coef_o == exp_val(code, pp), code == 2 ? "R7 R9" : "R6 R9",
            new_coef_o, exp_val(code, pp));
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk_idle("R3 held code");
    end
    eq_req_i = 2'b00;
    @(negedge clk_i);
    chk_idle("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R10");
    chk(lffs_sel_o == 1'b0, "R10 lffs", lffs_sel_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk_idle("R11 code 00");
    end
    for (int code = 1; code <= 3; code++)
      for (int pp = 0; pp < 16; pp++)
        for (int p = 0; p < 2; p++)
          run(code, pp, p[0]);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule